// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block sits beside the command bus of a four-bank synchronous DRAM and watches every clock edge. It turns the chip-select, row strobe, column strobe, write-enable, clock-enable, bank-select and A10 lines into one decoded command. It keeps a model of which banks hold an open row, of the burst in flight and of the quiet period that follows a mode-register write. When a command arrives in a state where it is not allowed, the block raises a sticky error flag and records a cause code.

The checker is passive. It drives nothing back onto the bus and it does not stop a bad command from reaching the memory. An illegal command is only reported, and the model of the memory stays as it was before that command. All outputs are registered. A command sampled at a rising edge shows up on `cmd_code`, `bank_open`, `err_flag` and `err_cause` right after that same edge.

Top module: `sdram_cmd_guard`

## Requirements
- R1: A command is sampled at the rising edge while both the previous and the current clock-enable are high, and `cmd_code` reports it after that edge. With `cs_n` high the code is NOP (0). With `cs_n` low, {ras_n,cas_n,we_n} decodes as follows: 111 is NOP (0), 011 is activate (1), 101 is read (2), 100 is write (3), 010 is precharge (4) when A10 is low and precharge-all (5) when A10 is high, 000 is mode set (6), 001 is auto refresh (7) and 110 is burst stop (10).
- R2: A legal activate sets bit `ba` of `bank_open`. Bit 0 is bank A (ba=00), bit 1 is bank B (01), bit 2 is bank C (10) and bit 3 is bank D (11).
- R3: A precharge with A10 low clears only the bit of the selected bank. A precharge with A10 high clears every bit and ignores `ba`.
- R4: A mode set while any bank is open is illegal, with cause 3.
- R5: For the two edges after a legal mode set, any command other than NOP or deselect is illegal, with cause 5. At the third edge, commands are legal again.
- R6: Auto refresh, and self-refresh entry, are illegal with cause 4 while any bank is open. Self-refresh entry is the refresh pattern with clock-enable falling (code 8). Clock-enable rising after a low cycle decodes as self-refresh exit (code 9). While clock-enable stays low, the code is NOP.
- R7: An activate to an open bank is illegal with cause 1. A read or write to an idle bank is illegal with cause 2.
- R8: A read or write with A10 high starts a burst with auto precharge. A read or write issued fewer than BURST_LEN edges after it is illegal with cause 6. A read or write exactly BURST_LEN edges after it is legal.
- R9: The bank of an auto-precharge burst issued at edge k reads as idle after edge k+BURST_LEN-1.
- R10: A read or write with A10 low may be cut short by a later read or write. A burst stop ends the current burst, so a following auto-precharge read is legal.
- R11: An illegal command changes neither the bank state, nor the burst, nor the mode-set lockout.
- R12: `err_flag` stays set until `err_clr` is high at an edge with no new error. While the flag is set, `err_cause` keeps the first cause. An error at the same edge as `err_clr` wins: the flag stays set and the cause becomes the new one.
- R13: After a synchronous reset, `cmd_code` is 0, `bank_open` is 0, `err_flag` is 0 and `err_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Precharge-all / auto-precharge line |
| err_clr | input | 1 | Clears the sticky error |
| cmd_code | output | 4 | Decoded command of the last edge |
| bank_open | output | 4 | One bit per bank, 1 = row open |
| err_flag | output | 1 | Sticky illegal-command flag |
| err_cause | output | 4 | Cause of the first error since the last clear |

## Verification
Each command pattern is tried with deselect, with every bank-select value and with both levels of A10. This tells apart a bank-select mapping that has been mirrored or shifted, and a precharge-all that looks at `ba`. Mode set and refresh are issued both with all banks idle and with one bank open, so the all-idle condition is tested from both sides. The edges just inside and just outside the lockout and the auto-precharge window are each tried with a command, which shows an off-by-one in either counter. Errors are stacked, and an error is also raised on the same edge as a clear. This tells first-cause retention, clear priority, and the rule that an illegal command leaves the model untouched (for example, a rejected mode set must not start a lockout).

// File: rtl/sdc_pkg.sv
// Package: command and error-cause codes shared by the legality checker.
// Assumes: 4-bit codes are enough for both sets of values.
package sdc_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_PREA = 4'd5,
        CMD_MRS  = 4'd6,
        CMD_REF  = 4'd7,
        CMD_SRE  = 4'd8,
        CMD_SRX  = 4'd9,
        CMD_BST  = 4'd10
    } cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE     = 4'd0,
        ERR_ACT_OPEN = 4'd1,
        ERR_RW_IDLE  = 4'd2,
        ERR_MRS_OPEN = 4'd3,
        ERR_REF_OPEN = 4'd4,
        ERR_LOCKOUT  = 4'd5,
        ERR_AP_BURST = 4'd6
    } cause_e;

endpackage

// File: rtl/sdc_cmd_decode.sv
// Module: turns the raw command pins into one command code per edge.
// Assumes: the pins are stable around the rising edge. It keeps one
// register of clock-enable history to spot self-refresh entry and exit.
module sdc_cmd_decode
    import sdc_pkg::*;
#(
    parameter int BANK_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke,
    input  logic [BANK_BITS-1:0] ba,
    input  logic                 a10,
    output cmd_e                 cmd,
    output logic [BANK_BITS-1:0] tgt_bank,
    output logic                 ap_req
);

    logic       cke_q;
    logic [2:0] strobes;

    // Keep the clock-enable level of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    assign strobes  = {ras_n, cas_n, we_n};
    assign tgt_bank = ba;
    assign ap_req   = a10;

    // Map the pin pattern and the clock-enable history to a command.
    always_comb begin
        cmd = CMD_NOP;
        if (!cke_q && cke) begin
            cmd = CMD_SRX;
        end else if (cke_q && !cke) begin
            if (!cs_n && strobes == 3'b001) cmd = CMD_SRE;
        end else if (cke_q && cke && !cs_n) begin
            case (strobes)
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    // R1: a deselected steady-clock edge never yields a real command.
    p_desel_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cke && cke_q) |-> (cmd == CMD_NOP));

endmodule

// File: rtl/sdc_rules.sv
// Module: combinational legality rules for the current command.
// Assumes: the bank, burst and lockout state come from sdc_bank_state.
// When several rules are broken at once, the lockout outranks the
// auto-precharge burst, which outranks the rules of each command.
module sdc_rules
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_BITS = 2
) (
    input  cmd_e                 cmd,
    input  logic [BANK_BITS-1:0] tgt_bank,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 ap_busy,
    input  logic                 lock_active,
    output logic                 illegal,
    output cause_e               cause
);

    logic bank_hit;
    logic any_open;
    logic is_rw;

    assign bank_hit = bank_open[tgt_bank];
    assign any_open = |bank_open;
    assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);

    // Pick the cause of the most important broken rule, if there is one.
    always_comb begin
        illegal = 1'b0;
        cause   = ERR_NONE;
        if (lock_active && cmd != CMD_NOP) begin
            illegal = 1'b1;
            cause   = ERR_LOCKOUT;
        end else if (is_rw && ap_busy) begin
            illegal = 1'b1;
            cause   = ERR_AP_BURST;
        end else begin
            case (cmd)
                CMD_ACT: if (bank_hit) begin
                    illegal = 1'b1;
                    cause   = ERR_ACT_OPEN;
                end
                CMD_RD, CMD_WR: if (!bank_hit) begin
                    illegal = 1'b1;
                    cause   = ERR_RW_IDLE;
                end
                CMD_MRS: if (any_open) begin
                    illegal = 1'b1;
                    cause   = ERR_MRS_OPEN;
                end
                CMD_REF, CMD_SRE: if (any_open) begin
                    illegal = 1'b1;
                    cause   = ERR_REF_OPEN;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdc_bank_state.sv
// Module: model of the memory. It holds the open-bank vector, the count of
// burst beats left with its auto-precharge bank, and the lockout count
// after a mode set.
// Assumes: 'illegal' comes from sdc_rules for the same command. An
// illegal command leaves all of this state untouched.
module sdc_bank_state
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BANK_BITS   = 2,
    parameter int BURST_LEN   = 4,
    parameter int LOCK_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_e                 cmd,
    input  logic [BANK_BITS-1:0] tgt_bank,
    input  logic                 ap_req,
    input  logic                 illegal,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 ap_busy,
    output logic                 lock_active
);

    localparam int RW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int LW = $clog2(LOCK_CYCLES + 1);
    localparam logic [RW-1:0] REM_START = RW'(BURST_LEN - 1);
    localparam logic [LW-1:0] LOCK_START = LW'(LOCK_CYCLES);

    logic [NUM_BANKS-1:0] open_q, open_n;
    logic [RW-1:0]        rem_q, rem_n;
    logic                 ap_q, ap_n;
    logic [BANK_BITS-1:0] apb_q, apb_n;
    logic [LW-1:0]        lock_q, lock_n;

    // Work out the next state from the current one and a legal command.
    always_comb begin
        open_n = open_q;
        rem_n  = (rem_q != '0) ? rem_q - 1'b1 : '0;
        ap_n   = ap_q;
        apb_n  = apb_q;
        lock_n = (lock_q != '0) ? lock_q - 1'b1 : '0;
        if (!illegal) begin
            case (cmd)
                CMD_ACT:  open_n[tgt_bank] = 1'b1;
                CMD_PRE:  open_n[tgt_bank] = 1'b0;
                CMD_PREA: open_n = '0;
                CMD_RD, CMD_WR: begin
                    rem_n = REM_START;
                    ap_n  = ap_req;
                    apb_n = tgt_bank;
                end
                CMD_BST:  rem_n = '0;
                CMD_MRS:  lock_n = LOCK_START;
                default:  ;
            endcase
        end
        if (ap_n && rem_n == '0) begin
            open_n[apb_n] = 1'b0;
            ap_n          = 1'b0;
        end
    end

    // Register the model state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
            rem_q  <= '0;
            ap_q   <= 1'b0;
            apb_q  <= '0;
            lock_q <= '0;
        end else begin
            open_q <= open_n;
            rem_q  <= rem_n;
            ap_q   <= ap_n;
            apb_q  <= apb_n;
            lock_q <= lock_n;
        end
    end

    assign bank_open   = open_q;
    assign ap_busy     = ap_q && (rem_q != '0);
    assign lock_active = (lock_q != '0);

    // R4: an accepted mode set only ever happens with every bank idle.
    p_mrs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS && !illegal) |-> (open_q == '0));

    // R5: during the lockout the rules reject everything except NOP.
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != '0 && cmd != CMD_NOP) |-> illegal);

    // R3: an accepted precharge-all leaves every bank idle.
    p_prea_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PREA && !illegal) |=> (open_q == '0));

    // R7: an accepted read or write targets an open bank.
    p_rw_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD || cmd == CMD_WR) && !illegal) |-> open_q[tgt_bank]);

    // R8: the beat counter never runs past one burst.
    p_rem_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= REM_START);

endmodule

// File: rtl/sdc_err_log.sv
// Module: sticky error flag, with the cause of the first error since the
// last clear.
// Assumes: a new error at the same edge as a clear takes precedence.
module sdc_err_log
    import sdc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   illegal,
    input  cause_e cause_in,
    input  logic   clr,
    output logic   flag,
    output cause_e cause
);

    // Set on error, keep the first cause, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            cause <= ERR_NONE;
        end else if (illegal) begin
            flag <= 1'b1;
            if (!flag || clr) cause <= cause_in;
        end else if (clr) begin
            flag  <= 1'b0;
            cause <= ERR_NONE;
        end
    end

    // R12: without a clear, the flag and its cause hold.
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> (flag && $stable(cause)));

endmodule

// File: rtl/sdram_cmd_guard.sv
// Module: top of the SDRAM command legality checker. It decodes the bus,
// checks each command against the bank model and logs the errors.
// Assumes: a passive monitor. All outputs are registered at the edge that
// samples the command.
module sdram_cmd_guard
    import sdc_pkg::*;
#(
    parameter int BANK_BITS   = 2,
    parameter int BURST_LEN   = 4,
    parameter int LOCK_CYCLES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic                          cke,
    input  logic [BANK_BITS-1:0]          ba,
    input  logic                          a10,
    input  logic                          err_clr,
    output logic [3:0]                    cmd_code,
    output logic [(1 << BANK_BITS)-1:0]   bank_open,
    output logic                          err_flag,
    output logic [3:0]                    err_cause
);

    localparam int NUM_BANKS = 1 << BANK_BITS;

    cmd_e                 cmd;
    logic [BANK_BITS-1:0] tgt_bank;
    logic                 ap_req;
    logic                 illegal;
    cause_e               cause_now;
    cause_e               cause_q;
    logic                 ap_busy;
    logic                 lock_active;
    cmd_e                 cmd_q;

    sdc_cmd_decode #(.BANK_BITS(BANK_BITS)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .a10(a10),
        .cmd(cmd), .tgt_bank(tgt_bank), .ap_req(ap_req)
    );

    sdc_rules #(.NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS)) u_rules (
        .cmd(cmd), .tgt_bank(tgt_bank), .bank_open(bank_open),
        .ap_busy(ap_busy), .lock_active(lock_active),
        .illegal(illegal), .cause(cause_now)
    );

    sdc_bank_state #(
        .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS),
        .BURST_LEN(BURST_LEN), .LOCK_CYCLES(LOCK_CYCLES)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .tgt_bank(tgt_bank),
        .ap_req(ap_req), .illegal(illegal), .bank_open(bank_open),
        .ap_busy(ap_busy), .lock_active(lock_active)
    );

    sdc_err_log u_log (
        .clk(clk), .rst_n(rst_n), .illegal(illegal), .cause_in(cause_now),
        .clr(err_clr), .flag(err_flag), .cause(cause_q)
    );

    // Register the decoded command for the output.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= CMD_NOP;
        else        cmd_q <= cmd;
    end

    assign cmd_code  = cmd_q;
    assign err_cause = cause_q;

    // R12: the flag and the recorded cause agree at every edge.
    p_flag_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == (cause_q != ERR_NONE));

endmodule

// File: tb/sim_sdram_cmd_guard.sv
`timescale 1ns/1ps
module sim_sdram_cmd_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       cke = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic       err_clr = 1'b0;
    logic [3:0] cmd_code;
    logic [3:0] bank_open;
    logic       err_flag;
    logic [3:0] err_cause;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sdram_cmd_guard u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .err_clr(err_clr),
        .cmd_code(cmd_code), .bank_open(bank_open), .err_flag(err_flag),
        .err_cause(err_cause)
    );

    // pin patterns {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] P_DES = 4'b1111;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_MRS = 4'b0000;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_BST = 4'b0110;

    // {pins, cke, ba, a10, clr, req, exp_cmd, exp_open, exp_flag, exp_cause}
    localparam int NV = 52;
    localparam logic [25:0] VEC [NV] = '{
        {P_DES,1'b1,2'd0,1'b0,1'b0,4'd1 ,4'd0 ,4'b0000,1'b0,4'd0}, // R1 deselect
        {P_ACT,1'b1,2'd0,1'b0,1'b0,4'd2 ,4'd1 ,4'b0001,1'b0,4'd0}, // R2 bank A
        {P_ACT,1'b1,2'd2,1'b0,1'b0,4'd2 ,4'd1 ,4'b0101,1'b0,4'd0}, // R2 bank C
        {P_ACT,1'b1,2'd3,1'b0,1'b0,4'd2 ,4'd1 ,4'b1101,1'b0,4'd0}, // R2 bank D
        {P_ACT,1'b1,2'd1,1'b0,1'b0,4'd2 ,4'd1 ,4'b1111,1'b0,4'd0}, // R2 bank B
        {P_PRE,1'b1,2'd2,1'b0,1'b0,4'd3 ,4'd4 ,4'b1011,1'b0,4'd0}, // R3 single
        {P_PRE,1'b1,2'd2,1'b1,1'b0,4'd3 ,4'd5 ,4'b0000,1'b0,4'd0}, // R3 all
        {P_MRS,1'b1,2'd0,1'b0,1'b0,4'd4 ,4'd6 ,4'b0000,1'b0,4'd0}, // R4 legal
        {P_NOP,1'b1,2'd0,1'b0,1'b0,4'd5 ,4'd0 ,4'b0000,1'b0,4'd0}, // R5
        {P_DES,1'b1,2'd0,1'b0,1'b0,4'd5 ,4'd0 ,4'b0000,1'b0,4'd0}, // R5
        {P_REF,1'b1,2'd0,1'b0,1'b0,4'd6 ,4'd7 ,4'b0000,1'b0,4'd0}, // R6 legal
        {P_ACT,1'b1,2'd1,1'b0,1'b0,4'd2 ,4'd1 ,4'b0010,1'b0,4'd0}, // R2
        {P_WR ,1'b1,2'd1,1'b0,1'b0,4'd1 ,4'd3 ,4'b0010,1'b0,4'd0}, // R1 write
        {P_RD ,1'b1,2'd1,1'b0,1'b0,4'd10,4'd2 ,4'b0010,1'b0,4'd0}, // R10 interrupt
        {P_BST,1'b1,2'd0,1'b0,1'b0,4'd10,4'd10,4'b0010,1'b0,4'd0}, // R10 stop
        {P_RD ,1'b1,2'd1,1'b1,1'b0,4'd10,4'd2 ,4'b0010,1'b0,4'd0}, // R10 AP after stop
        {P_NOP,1'b1,2'd0,1'b0,1'b0,4'd9 ,4'd0 ,4'b0010,1'b0,4'd0}, // R9
        {P_NOP,1'b1,2'd0,1'b0,1'b0,4'd9 ,4'd0 ,4'b0010,1'b0,4'd0}, // R9
        {P_NOP,1'b1,2'd0,1'b0,1'b0,4'd9 ,4'd0 ,4'b0000,1'b0,4'd0}, // R9 closed
        {P_ACT,1'b1,2'd0,1'b0,1'b0,4'd2 ,4'd1 ,4'b0001,1'b0,4'd0}, // R2
        {P_RD ,1'b1,2'd0,1'b1,1'b0,4'd8 ,4'd2 ,4'b0001,1'b0,4'd0}, // R8 AP start
        {P_WR ,1'b1,2'd0,1'b0,1'b0,4'd8 ,4'd3 ,4'b0001,1'b1,4'd6}, // R8 too early
        {P_NOP,1'b1,2'd0,1'b0,1'b0,4'd12,4'd0 ,4'b0001,1'b1,4'd6}, // R12 sticky
        {P_ACT,1'b1,2'd0,1'b0,1'b0,4'd12,4'd1 ,4'b0000,1'b1,4'd6}, // R12 first cause, R7
        {P_NOP,1'b1,2'd0,1'b0,1'b1,4'd12,4'd0 ,4'b0000,1'b0,4'd0}, // R12 clear
        {P_RD ,1'b1,2'd2,1'b0,1'b0,4'd7 ,4'd2 ,4'b0000,1'b1,4'd2}, // R7 idle read
        {P_NOP,1'b1,2'd0,1'b0,1'b1,4'd12,4'd0 ,4'b0000,1'b0,4'd0}, // R12
        {P_ACT,1'b1,2'd3,1'b0,1'b0,4'd2 ,4'd1 ,4'b1000,1'b0,4'd0}, // R2
        {P_MRS,1'b1,2'd0,1'b0,1'b0,4'd4 ,4'd6 ,4'b1000,1'b1,4'd3}, // R4 open bank
        {P_ACT,1'b1,2'd3,1'b0,1'b1,4'd11,4'd1 ,4'b1000,1'b1,4'd1}, // R11 no lockout, R12
        {P_NOP,1'b1,2'd0,1'b0,1'b1,4'd12,4'd0 ,4'b1000,1'b0,4'd0}, // R12
        {P_REF,1'b1,2'd0,1'b0,1'b0,4'd6 ,4'd7 ,4'b1000,1'b1,4'd4}, // R6 open bank
        {P_NOP,1'b1,2'd0,1'b0,1'b1,4'd12,4'd0 ,4'b1000,1'b0,4'd0}, // R12
        {P_PRE,1'b1,2'd0,1'b1,1'b0,4'd3 ,4'd5 ,4'b0000,1'b0,4'd0}, // R3
        {P_MRS,1'b1,2'd0,1'b0,1'b0,4'd4 ,4'd6 ,4'b0000,1'b0,4'd0}, // R4
        {P_ACT,1'b1,2'd0,1'b0,1'b0,4'd5 ,4'd1 ,4'b0000,1'b1,4'd5}, // R5 lockout, R11
        {P_NOP,1'b1,2'd0,1'b0,1'b1,4'd5 ,4'd0 ,4'b0000,1'b0,4'd0}, // R5 second edge
        {P_ACT,1'b1,2'd0,1'b0,1'b0,4'd5 ,4'd1 ,4'b0001,1'b0,4'd0}, // R5 third edge ok
        {P_PRE,1'b1,2'd0,1'b0,1'b0,4'd3 ,4'd4 ,4'b0000,1'b0,4'd0}, // R3
        {P_REF,1'b0,2'd0,1'b0,1'b0,4'd6 ,4'd8 ,4'b0000,1'b0,4'd0}, // R6 SR entry
        {P_NOP,1'b0,2'd0,1'b0,1'b0,4'd6 ,4'd0 ,4'b0000,1'b0,4'd0}, // R6 cke low
        {P_DES,1'b1,2'd0,1'b0,1'b0,4'd6 ,4'd9 ,4'b0000,1'b0,4'd0}, // R6 SR exit
        {P_ACT,1'b1,2'd1,1'b0,1'b0,4'd2 ,4'd1 ,4'b0010,1'b0,4'd0}, // R2
        {P_REF,1'b0,2'd0,1'b0,1'b0,4'd6 ,4'd8 ,4'b0010,1'b1,4'd4}, // R6 SR entry open
        {P_NOP,1'b1,2'd0,1'b0,1'b1,4'd6 ,4'd9 ,4'b0010,1'b0,4'd0}, // R6 exit, clear
        {P_ACT,1'b1,2'd2,1'b0,1'b0,4'd2 ,4'd1 ,4'b0110,1'b0,4'd0}, // R2
        {P_WR ,1'b1,2'd1,1'b1,1'b0,4'd9 ,4'd3 ,4'b0110,1'b0,4'd0}, // R9 AP write
        {P_NOP,1'b1,2'd0,1'b0,1'b0,4'd9 ,4'd0 ,4'b0110,1'b0,4'd0}, // R9
        {P_NOP,1'b1,2'd0,1'b0,1'b0,4'd9 ,4'd0 ,4'b0110,1'b0,4'd0}, // R9
        {P_NOP,1'b1,2'd0,1'b0,1'b0,4'd9 ,4'd0 ,4'b0100,1'b0,4'd0}, // R9 closed
        {P_RD ,1'b1,2'd2,1'b0,1'b0,4'd8 ,4'd2 ,4'b0100,1'b0,4'd0}, // R8 boundary ok
        {P_BST,1'b1,2'd0,1'b0,1'b0,4'd1 ,4'd10,4'b0100,1'b0,4'd0}  // R1 burst stop
    };

    task automatic chk(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] pins, input logic ck,
                         input logic [1:0] b, input logic a, input logic c);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = pins;
        cke = ck; ba = b; a10 = a; err_clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_all(input string req, input logic [3:0] ec,
                           input logic [3:0] eo, input logic ef,
                           input logic [3:0] ecause);
        chk(req, "cmd_code", cmd_code, ec);
        chk(req, "bank_open", bank_open, eo);
        chk(req, "err_flag", {3'b0, err_flag}, {3'b0, ef});
        chk(req, "err_cause", err_cause, ecause);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_all("R13", 4'd0, 4'b0000, 1'b0, 4'd0); // reset state
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            drive(v[25:22], v[21], v[20:19], v[18], v[17]);
            chk_all($sformatf("R%0d step %0d", v[16:13], i),
                    v[12:9], v[8:5], v[4], v[3:0]);
        end
        // R7: activate of bank C, already open, then a mid-run reset (R13)
        drive(P_ACT, 1'b1, 2'd2, 1'b0, 1'b0);
        chk_all("R7", 4'd1, 4'b0100, 1'b1, 4'd1);
        @(negedge clk);
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = P_ACT;
        ba = 2'd0;
        @(posedge clk);
        #1;
        chk_all("R13", 4'd0, 4'b0000, 1'b0, 4'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule